// File: doc/BRIEF.md
# Interval sampling transfer controller

This block sequences position snapshots from two cart position counters out to a host through a byte-wide USB FIFO bridge. After reset it waits for the host to deliver one command byte through the bridge's read handshake. That byte picks the sampling interval, either the long (10 ms) or the short (5 ms) interval. Every interval tick after that, the block captures both 16-bit position counters on the same clock edge and streams the 32-bit snapshot to the host as four bytes. When the run has its full number of snapshots it goes back to waiting for a command.

The bridge side has two active-low status inputs. `host_has_byte_n` low means a byte can be fetched. `host_room_n` low means the bridge can accept a byte. These act as the valid and ready of the inbound and outbound streams.

The back-pressure rules are as follows:
- Inbound: a byte is fetched only while the block waits for a command and `host_has_byte_n` is low. Bytes that arrive during a run stay in the bridge.
- Outbound: while `host_room_n` is high, no write strobe starts and the pending snapshot is held.
- Overrun: if the next tick arrives before the held snapshot is fully sent, that tick's snapshot is dropped and a sticky flag is raised. The tick timing is not shifted.

The bidirectional bus is split into input, output and output-enable pins. The pad tristate is left to the chip top.

Top module: `interval_sample_xfer`

## Requirements
- R1: During and after reset, `rd_n` and `wr_n` are high, `bus_oe` is low and `overrun` is low.
- R2: While the block waits for a command, byte 0x01 starts a run with a period of TICKS_LONG cycles and byte 0x02 starts a run with a period of TICKS_SHORT cycles. Any other byte is read, discarded and produces no output bytes, and the block keeps waiting.
- R3: A read cycle starts only while the block is waiting and `host_has_byte_n` is low. `rd_n` then stays low for exactly RD_LOW_CYCLES (4) cycles, and the byte is latched on the last of them. No read cycle starts during a run.
- R4: During a run, both position inputs are captured on the same edge once per period. Consecutive captures are exactly one period apart, so the first bytes of consecutive snapshots appear exactly one period apart when the bridge has room.
- R5: Each snapshot is sent as four bytes in this order: cart1[7:0], cart1[15:8], cart2[7:0], cart2[15:8].
- R6: A write waits while `host_room_n` is high. For each write, `bus_oe` is high with the byte on `bus_out` one cycle before `wr_n` falls. `wr_n` stays low for WR_LOW_CYCLES (2) cycles, and `bus_oe` stays high for two cycles after `wr_n` rises. `bus_out` is stable throughout.
- R7: A run holds exactly SAMPLES ticks. After it, no further bytes are sent and the block waits for the next command.
- R8: If a tick comes while the previous snapshot is not fully sent, that snapshot is dropped and `overrun` goes high. The tick timing is unchanged. `overrun` stays high until the next valid command is accepted.
- R9: `bus_oe` is never high while `rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| cart1_pos | input | POS_W | Position counter of cart 1 |
| cart2_pos | input | POS_W | Position counter of cart 2 |
| host_has_byte_n | input | 1 | Low when the bridge holds a byte from the host |
| host_room_n | input | 1 | Low when the bridge can accept a byte |
| bus_in | input | 8 | Bus value read from the bridge |
| bus_out | output | 8 | Byte driven toward the bridge |
| bus_oe | output | 1 | High while the block drives the bus |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| overrun | output | 1 | Sticky flag: a snapshot was dropped in this run |

## Verification
The two functions that can fall in the same cycle are the interval tick and the byte sender still working on the previous snapshot. The bench provokes this by holding `host_room_n` high across several ticks of a short-interval run. It then releases the stall and checks three things: `overrun` is set, only the first snapshot's four bytes ever appear, and the flag survives until the next command is accepted. A second, shorter stall, released before the next tick, checks that the tick spacing stays exact and that no strobe falls while the bridge is full.

// File: rtl/ist_pkg.sv
package ist_pkg;
  typedef enum logic [1:0] {SEQ_WAIT_CMD, SEQ_RUN, SEQ_DRAIN} seq_state_t;
  typedef enum logic [1:0] {RD_IDLE, RD_LOW, RD_REC} rd_state_t;
  typedef enum logic [2:0] {WR_IDLE, WR_WAIT, WR_SETUP, WR_STROBE, WR_HOLD} wr_state_t;
  localparam logic [7:0] CMD_LONG  = 8'h01;
  localparam logic [7:0] CMD_SHORT = 8'h02;
endpackage

// File: rtl/ist_cmd_reader.sv
module ist_cmd_reader
  import ist_pkg::*;
#(
  parameter int RD_LOW_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       host_has_byte_n,
  input  logic [7:0] bus_in,
  output logic       rd_n,
  output logic       byte_vld,
  output logic [7:0] byte_q
);
  localparam int CW = $clog2(RD_LOW_CYCLES + 1);

  rd_state_t       state;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RD_IDLE;
      cnt    <= '0;
      byte_q <= '0;
    end else begin
      case (state)
        RD_IDLE: begin
          cnt <= '0;
          if (enable && !host_has_byte_n) state <= RD_LOW;
        end
        RD_LOW: begin
          if (cnt == CW'(RD_LOW_CYCLES - 1)) begin
            byte_q <= bus_in;
            state  <= RD_REC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  assign rd_n     = (state != RD_LOW);
  assign byte_vld = (state == RD_REC);
endmodule

// File: rtl/ist_tick_timer.sv
module ist_tick_timer #(
  parameter int PERIOD_W = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt;
  logic                at_end;

  assign at_end = (cnt == period - PERIOD_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (at_end)    cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ist_byte_sender.sv
module ist_byte_sender
  import ist_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int WR_LOW_CYCLES = 2,
  parameter int HOLD_CYCLES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              host_room_n,
  output logic              busy,
  output logic              wr_n,
  output logic              bus_oe,
  output logic [7:0]        bus_out
);
  localparam int NBYTES = WORD_W / 8;
  localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int TMAX   = (WR_LOW_CYCLES > HOLD_CYCLES) ? WR_LOW_CYCLES : HOLD_CYCLES;
  localparam int TW     = $clog2(TMAX + 1);

  wr_state_t         state;
  logic [WORD_W-1:0] shreg;
  logic [IW-1:0]     idx;
  logic [TW-1:0]     tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WR_IDLE;
      shreg <= '0;
      idx   <= '0;
      tcnt  <= '0;
    end else begin
      case (state)
        WR_IDLE: if (load) begin
          shreg <= word;
          idx   <= '0;
          state <= WR_WAIT;
        end
        WR_WAIT: if (!host_room_n) state <= WR_SETUP;
        WR_SETUP: begin
          tcnt  <= '0;
          state <= WR_STROBE;
        end
        WR_STROBE: begin
          if (tcnt == TW'(WR_LOW_CYCLES - 1)) begin
            tcnt  <= '0;
            state <= WR_HOLD;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        WR_HOLD: begin
          if (tcnt == TW'(HOLD_CYCLES - 1)) begin
            tcnt <= '0;
            if (idx == IW'(NBYTES - 1)) begin
              state <= WR_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              shreg <= shreg >> 8;
              state <= WR_WAIT;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= WR_IDLE;
      endcase
    end
  end

  assign bus_out = shreg[7:0];
  assign bus_oe  = (state == WR_SETUP) || (state == WR_STROBE) || (state == WR_HOLD);
  assign wr_n    = (state != WR_STROBE);
  assign busy    = (state != WR_IDLE);
endmodule

// File: rtl/interval_sample_xfer.sv
module interval_sample_xfer
  import ist_pkg::*;
#(
  parameter int POS_W         = 16,
  parameter int TICKS_LONG    = 120000,
  parameter int TICKS_SHORT   = 60000,
  parameter int SAMPLES       = 600,
  parameter int RD_LOW_CYCLES = 4,
  parameter int WR_LOW_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] cart1_pos,
  input  logic [POS_W-1:0] cart2_pos,
  input  logic             host_has_byte_n,
  input  logic             host_room_n,
  input  logic [7:0]       bus_in,
  output logic [7:0]       bus_out,
  output logic             bus_oe,
  output logic             rd_n,
  output logic             wr_n,
  output logic             overrun
);
  localparam int PMAX     = (TICKS_LONG > TICKS_SHORT) ? TICKS_LONG : TICKS_SHORT;
  localparam int PERIOD_W = $clog2(PMAX + 1);
  localparam int CNT_W    = $clog2(SAMPLES + 1);
  localparam int WORD_W   = 2 * POS_W;

  seq_state_t          state;
  logic [PERIOD_W-1:0] period_q;
  logic [CNT_W-1:0]    taken;
  logic                byte_vld;
  logic [7:0]          byte_q;
  logic                tick;
  logic                busy;
  logic                run;
  logic                load;
  logic                seq_waiting;

  assign run         = (state == SEQ_RUN);
  assign seq_waiting = (state == SEQ_WAIT_CMD);
  assign load        = run && tick && !busy;

  ist_cmd_reader #(.RD_LOW_CYCLES(RD_LOW_CYCLES)) u_reader (
    .clk(clk), .rst_n(rst_n), .enable(seq_waiting),
    .host_has_byte_n(host_has_byte_n), .bus_in(bus_in),
    .rd_n(rd_n), .byte_vld(byte_vld), .byte_q(byte_q)
  );

  ist_tick_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .period(period_q), .tick(tick)
  );

  ist_byte_sender #(.WORD_W(WORD_W), .WR_LOW_CYCLES(WR_LOW_CYCLES), .HOLD_CYCLES(2)) u_sender (
    .clk(clk), .rst_n(rst_n), .load(load), .word({cart2_pos, cart1_pos}),
    .host_room_n(host_room_n), .busy(busy), .wr_n(wr_n),
    .bus_oe(bus_oe), .bus_out(bus_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_WAIT_CMD;
      period_q <= PERIOD_W'(TICKS_LONG);
      taken    <= '0;
      overrun  <= 1'b0;
    end else begin
      case (state)
        SEQ_WAIT_CMD: begin
          if (byte_vld && (byte_q == CMD_LONG || byte_q == CMD_SHORT)) begin
            period_q <= (byte_q == CMD_LONG) ? PERIOD_W'(TICKS_LONG) : PERIOD_W'(TICKS_SHORT);
            taken    <= '0;
            overrun  <= 1'b0;
            state    <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (tick) begin
            if (busy) overrun <= 1'b1;
            taken <= taken + 1'b1;
            if (taken == CNT_W'(SAMPLES - 1)) state <= SEQ_DRAIN;
          end
        end
        SEQ_DRAIN: if (!busy) state <= SEQ_WAIT_CMD;
        default: state <= SEQ_WAIT_CMD;
      endcase
    end
  end
endmodule

// File: rtl/ist_checker.sv
module ist_checker #(
  parameter int RD_LOW_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_has_byte_n,
  input logic       host_room_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       bus_oe,
  input logic [7:0] bus_out,
  input logic       overrun,
  input logic       in_wait
);
  logic [7:0] rd_low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || rd_n) rd_low_cnt <= '0;
    else if (rd_low_cnt != 8'hFF) rd_low_cnt <= rd_low_cnt + 1'b1;
  end

  assert_read_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (!$past(host_has_byte_n) && $past(in_wait)));

  assert_read_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (rd_low_cnt == 8'(RD_LOW_CYCLES)));

  assert_write_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> !$past(host_room_n, 2));

  assert_write_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(bus_oe));

  assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> bus_oe);

  assert_write_hold2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |=> bus_oe);

  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_out));

  assert_no_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && bus_oe));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(in_wait));
endmodule

bind interval_sample_xfer ist_checker #(.RD_LOW_CYCLES(RD_LOW_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_has_byte_n(host_has_byte_n),
  .host_room_n(host_room_n), .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe),
  .bus_out(bus_out), .overrun(overrun), .in_wait(seq_waiting)
);

// File: tb/interval_sample_xfer_test.sv
module interval_sample_xfer_test;
  localparam int CLK_PERIOD = 10;
  localparam int T_LONG     = 300;
  localparam int T_SHORT    = 150;
  localparam int NSAMP      = 3;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 6;
  // command byte, expected period (0 = ignored), stall flag, no-read-during-run flag
  localparam logic [7:0] VEC_CMD [NVEC] = '{8'h01, 8'h05, 8'h02, 8'h00, 8'hFF, 8'h01};
  localparam int         VEC_PER [NVEC] = '{T_LONG, 0, T_SHORT, 0, 0, T_LONG};
  localparam bit         VEC_STL [NVEC] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam bit         VEC_NRD [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 0, rst_n = 0;
  logic [15:0] cart1_pos = 0, cart2_pos = 0;
  logic host_has_byte_n = 1, host_room_n = 0;
  logic [7:0] bus_in = 0, bus_out;
  logic bus_oe, rd_n, wr_n, overrun;

  int checks = 0, failures = 0, cyc = 0;
  int nbytes = 0, rd_falls = 0;
  logic [7:0] byte_log [64];
  int byte_cyc [64];
  bit stall_guard = 0;

  interval_sample_xfer #(.POS_W(16), .TICKS_LONG(T_LONG), .TICKS_SHORT(T_SHORT),
    .SAMPLES(NSAMP), .RD_LOW_CYCLES(4), .WR_LOW_CYCLES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cart1_pos(cart1_pos), .cart2_pos(cart2_pos),
    .host_has_byte_n(host_has_byte_n), .host_room_n(host_room_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .rd_n(rd_n), .wr_n(wr_n), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bus monitor, sampled away from the active edge
  logic prev_wr = 1, prev_oe = 0, prev_rd = 1;
  int wr_len = 0, rd_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!wr_n && prev_wr) begin
        chk(prev_oe, "R6 data driven before strobe", prev_oe, 1);
        chk(!stall_guard, "R6 strobe while bridge full", stall_guard, 0);
        if (nbytes < 64) begin
          byte_log[nbytes] = bus_out;
          byte_cyc[nbytes] = cyc;
        end
        nbytes++;
      end
      if (!wr_n) wr_len++;
      else if (!prev_wr) begin
        chk(wr_len == 2, "R6 strobe width", wr_len, 2);
        chk(bus_oe, "R6 hold after strobe", bus_oe, 1);
        wr_len = 0;
      end
      if (!rd_n && prev_rd) rd_falls++;
      if (!rd_n) rd_len++;
      else if (!prev_rd) begin
        chk(rd_len == 4, "R3 read strobe width", rd_len, 4);
        rd_len = 0;
      end
      chk(!(bus_oe && !rd_n), "R9 bus conflict", bus_oe, 0);
    end
    prev_wr = wr_n; prev_oe = bus_oe; prev_rd = rd_n;
  end

  function automatic logic [15:0] p1(input int v, input int k);
    return 16'(32'h1234 + v * 32'h0301 + k * 32'h0111);
  endfunction
  function automatic logic [15:0] p2(input int v, input int k);
    return 16'(32'hC0DE ^ (v * 32'h0807 + k * 32'h1020));
  endfunction

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    bus_in = b;
    host_has_byte_n = 0;
    while (rd_n) @(negedge clk);
    while (!rd_n) @(negedge clk);
    host_has_byte_n = 1;
  endtask

  task automatic wait_bytes(input int n);
    while (nbytes < n) @(negedge clk);
  endtask

  task automatic check_sample(input int at, input int v, input int k, input string tag);
    logic [15:0] a, b;
    a = p1(v, k); b = p2(v, k);
    chk(byte_log[at]   == a[7:0],  tag, byte_log[at],   a[7:0]);
    chk(byte_log[at+1] == a[15:8], tag, byte_log[at+1], a[15:8]);
    chk(byte_log[at+2] == b[7:0],  tag, byte_log[at+2], b[7:0]);
    chk(byte_log[at+3] == b[15:8], tag, byte_log[at+3], b[15:8]);
  endtask

  task automatic run_vec(input int v);
    int base, per, rdb;
    base = nbytes; per = VEC_PER[v];
    cart1_pos = p1(v, 0); cart2_pos = p2(v, 0);
    send_cmd(VEC_CMD[v]);
    if (per == 0) begin
      wait_cycles(2 * T_LONG);
      chk(nbytes == base, "R2 ignored command sends nothing", nbytes - base, 0);
      return;
    end
    rdb = rd_falls;
    for (int k = 0; k < NSAMP; k++) begin
      if (k == 0 && VEC_STL[v]) begin
        wait_bytes(base + 1);
        host_room_n = 1;
        wait_cycles(3);
        stall_guard = 1;
        wait_cycles(40);
        stall_guard = 0;
        host_room_n = 0;
      end
      wait_bytes(base + 4 * (k + 1));
      cart1_pos = p1(v, k + 1); cart2_pos = p2(v, k + 1);
      if (VEC_NRD[v] && k == 0) begin
        bus_in = 8'h01;
        host_has_byte_n = 0;
      end
      if (VEC_NRD[v] && k == 1) begin
        host_has_byte_n = 1;
        chk(rd_falls == rdb, "R3 no read during run", rd_falls - rdb, 0);
      end
    end
    for (int k = 0; k < NSAMP; k++) begin
      check_sample(base + 4 * k, v, k, "R5 byte order");
      if (k > 0)
        chk(byte_cyc[base + 4*k] - byte_cyc[base + 4*(k-1)] == per, "R4 tick spacing",
            byte_cyc[base + 4*k] - byte_cyc[base + 4*(k-1)], per);
    end
    wait_cycles(2 * per);
    chk(nbytes == base + 4 * NSAMP, "R7 run length", nbytes - base, 4 * NSAMP);
  endtask

  initial begin
    wait_cycles(4);
    chk(rd_n && wr_n && !bus_oe && !overrun, "R1 reset outputs",
        {rd_n, wr_n, bus_oe, overrun}, 4'b1100);
    @(negedge clk); rst_n = 1;
    wait_cycles(3);
    chk(rd_n && wr_n && !bus_oe && !overrun, "R1 idle after reset",
        {rd_n, wr_n, bus_oe, overrun}, 4'b1100);

    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R8: tick collides with a snapshot still waiting for room
    begin
      int base;
      chk(!overrun, "R8 flag clear before collision", overrun, 0);
      base = nbytes;
      cart1_pos = p1(9, 0); cart2_pos = p2(9, 0);
      host_room_n = 1;
      send_cmd(8'h02);
      wait_cycles(2 * T_SHORT + 20);
      chk(overrun, "R8 overrun set", overrun, 1);
      chk(nbytes == base, "R8 nothing sent while full", nbytes - base, 0);
      cart1_pos = p1(9, 5); cart2_pos = p2(9, 5);
      wait_cycles(T_SHORT + 40);
      host_room_n = 0;
      wait_cycles(60);
      chk(nbytes == base + 4, "R8 only held snapshot sent", nbytes - base, 4);
      check_sample(base, 9, 0, "R8 held snapshot intact");
      wait_cycles(2 * T_SHORT);
      chk(nbytes == base + 4, "R8 dropped snapshots stay dropped", nbytes - base, 4);
      chk(overrun, "R8 overrun sticky", overrun, 1);
      send_cmd(8'h01);
      wait_cycles(2);
      chk(!overrun, "R8 cleared by new command", overrun, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule